// File: doc/BRIEF.md
# Nonvolatile Array Command Sequencer

This block sits between a processor bus and an on-chip nonvolatile memory array. Software starts an operation in three steps. It writes a byte into the array address space, which latches the target address and data. It writes an operation code into the command register. It then writes 1 to the buffer-empty flag of the status register, which hands the operation to the array. Two commands can be held at once, one running and one waiting, so a stream of burst program operations can be queued without gaps in software handshaking.

The status register holds two sticky error flags that are cleared by writing 1: a protection-violation flag and an access-error flag. It also holds a read-only completion flag and a read-only erase-check result. While either error flag is set, the sequencer accepts no new steps. A behavioural array model inside the block executes each command after a configurable latency. It tracks which pages hold programmed data, so that an erase check reports whether the whole array is blank.

Operation codes are 7 bits: 0x05 erase check, 0x20 byte program, 0x25 burst program, 0x40 page erase, 0x41 full erase. The array address is AW bits. Its top PG_BITS bits select the page. Addresses at or above PROT_BASE are protected. With the defaults (AW=10, PG_BITS=3, PROT_BASE=0x300, LAT=4), pages 6 and 7 are protected.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status register reads 0xC0 and the command register reads 0x00. Status bit 7 is buffer-empty (BE), bit 6 is complete (CC), bit 5 is protection violation (PV), bit 4 is access error (AE) and bit 2 is blank (BL).
- R2: A valid sequence (array write, then a valid code, then a status write with bit 7 = 1) launches the command. From the next cycle CC reads 0. BE reads 0 only while two commands are held, and stays 1 while a slot is free.
- R3: CC sets only when no command is running or waiting. It does not set when one command finishes and the waiting command starts.
- R4: A status write with bit 7 = 0 after the array write and before launch aborts the sequence and sets AE. The same write outside a sequence changes nothing.
- R5: AE sets in four cases: an undefined code; a command write that does not follow an array write; a second array write within one sequence; a launch attempt before a valid code has been accepted.
- R6: A program or erase code whose target address is protected sets PV, and nothing is queued. A full erase is protected when any protection is configured.
- R7: Writing 1 to status bit 4 clears AE, and writing 1 to bit 5 clears PV. Writing 0 to either bit leaves it unchanged.
- R8: While PV or AE is set, array writes, command writes and launch attempts are ignored. The command register and CC then keep their values.
- R9: If the stop request is high while CC is 0, AE sets. If it is high while CC is 1, nothing changes.
- R10: When an erase check finishes, BL shows the result: 1 means no page holds programmed data. A launch clears BL. Writes to bits 6 and 2 have no effect.
- R11: Command register bit 7 always reads 0. Status bits 3, 1 and 0 always read 0.
- R12: A lone command sets CC exactly LAT+3 cycles after the launch edge. A waiting command completes LAT+3 cycles after the command ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_wr | input | 1 | Write strobe into the array address space |
| arr_addr | input | AW | Array byte address |
| arr_wdata | input | 8 | Data byte to program |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 command |
| reg_wdata | input | 8 | Register write data |
| stop_req | input | 1 | Low-power stop request |
| stat_q | output | 8 | Status register value |
| cmd_q | output | 8 | Command register value |

## Verification
The properties assume at most one strobe per cycle: arr_wr and reg_wr are never high together. The bench drives only one strobe at a time and holds it for exactly one cycle. The properties also assume that the stop request is a single cycle pulse that is not combined with a register write. The stimulus respects this as well. The bench never combines a launch with an error-clear in one write, so the order in which those two take effect within a cycle is not exercised.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [6:0] {
    OP_VERIFY = 7'h05,
    OP_PROG   = 7'h20,
    OP_BURST  = 7'h25,
    OP_PERASE = 7'h40,
    OP_MERASE = 7'h41
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_CMD  = 2'd2
  } seq_e;

  function automatic logic op_valid(input logic [6:0] c);
    case (c)
      OP_VERIFY, OP_PROG, OP_BURST, OP_PERASE, OP_MERASE: op_valid = 1'b1;
      default: op_valid = 1'b0;
    endcase
  endfunction

  function automatic logic op_modifies(input logic [6:0] c);
    op_modifies = (c != OP_VERIFY);
  endfunction

endpackage

// File: rtl/flash_seq_check.sv
module flash_seq_check
  import flash_seq_pkg::*;
#(
  parameter int AW        = 10,
  parameter int PG_BITS   = 3,
  parameter int PROT_BASE = 'h300,
  localparam int EW       = 7 + PG_BITS + 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          err_blk,
  input  logic          cbef,
  input  logic          ccf,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic [7:0]    arr_wdata,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          stop_req,
  output logic          launch,
  output logic          acc_set,
  output logic          pv_set,
  output logic          cmd_we,
  output logic          active,
  output logic [EW-1:0] entry
);

  localparam int  NSPAN    = 1 << AW;
  localparam logic ANY_PROT = (PROT_BASE < NSPAN);

  seq_e          state, nstate;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [6:0]    code_q;
  logic          cap_addr, cap_cmd, hit;
  logic [6:0]    wcode;

  assign wcode  = reg_wdata[6:0];
  assign active = (state != SQ_IDLE);
  assign entry  = {code_q, addr_q[AW-1 -: PG_BITS], data_q};

  always_comb begin
    if (wcode == OP_MERASE) hit = ANY_PROT;
    else                    hit = (addr_q >= AW'(PROT_BASE));
  end

  always_comb begin
    nstate   = state;
    launch   = 1'b0;
    acc_set  = 1'b0;
    pv_set   = 1'b0;
    cap_addr = 1'b0;
    cap_cmd  = 1'b0;
    cmd_we   = 1'b0;
    if (!err_blk) begin
      if (arr_wr) begin
        if (state == SQ_IDLE && cbef) begin
          nstate   = SQ_ADDR;
          cap_addr = 1'b1;
        end else begin
          acc_set = 1'b1;
          nstate  = SQ_IDLE;
        end
      end else if (reg_wr && reg_sel) begin
        cmd_we = 1'b1;
        if (state != SQ_ADDR) begin
          acc_set = 1'b1;
          nstate  = SQ_IDLE;
        end else if (!op_valid(wcode)) begin
          acc_set = 1'b1;
          nstate  = SQ_IDLE;
        end else if (op_modifies(wcode) && hit) begin
          pv_set = 1'b1;
          nstate = SQ_IDLE;
        end else begin
          cap_cmd = 1'b1;
          nstate  = SQ_CMD;
        end
      end else if (reg_wr && !reg_sel) begin
        if (reg_wdata[7]) begin
          if (state == SQ_CMD) launch  = 1'b1;
          else                 acc_set = 1'b1;
          nstate = SQ_IDLE;
        end else if (state != SQ_IDLE) begin
          acc_set = 1'b1;
          nstate  = SQ_IDLE;
        end
      end
    end
    if (stop_req && !ccf) begin
      acc_set = 1'b1;
      nstate  = SQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      addr_q <= '0;
      data_q <= '0;
      code_q <= '0;
    end else begin
      state <= nstate;
      if (cap_addr) begin
        addr_q <= arr_addr;
        data_q <= arr_wdata;
      end
      if (cap_cmd) code_q <= wcode;
    end
  end

endmodule

// File: rtl/flash_cmd_fifo.sv
module flash_cmd_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  assign head = mem[rd_p];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else begin
      if (push) wr_p <= bump(wr_p);
      if (pop)  rd_p <= bump(rd_p);
      count <= count + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/flash_array_stub.sv
module flash_array_stub
  import flash_seq_pkg::*;
#(
  parameter int PG_BITS = 3,
  parameter int LAT     = 4,
  localparam int NPG    = 1 << PG_BITS,
  localparam int TW     = $clog2(LAT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [6:0]         op,
  input  logic [PG_BITS-1:0] pg,
  input  logic [7:0]         data,
  output logic               done,
  output logic               blank
);

  logic [NPG-1:0] dirty;
  logic [TW-1:0]  timer;
  logic           run;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty <= '0;
      timer <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
      blank <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run   <= 1'b1;
        timer <= TW'(LAT - 1);
      end else if (run) begin
        if (timer == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
          case (op)
            OP_VERIFY: blank <= (dirty == '0);
            OP_PROG, OP_BURST: if (data != 8'hFF) dirty[pg] <= 1'b1;
            OP_PERASE: dirty[pg] <= 1'b0;
            OP_MERASE: dirty <= '0;
            default: ;
          endcase
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 10,
  parameter int PG_BITS   = 3,
  parameter int PROT_BASE = 'h300,
  parameter int DEPTH     = 2,
  parameter int LAT       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic [7:0]    arr_wdata,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          stop_req,
  output logic [7:0]    stat_q,
  output logic [7:0]    cmd_q
);

  localparam int EW = 7 + PG_BITS + 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic          cbef_r, ccf_r, pv_r, acc_r, blank_r;
  logic [6:0]    cmd_r;
  logic          err_blk, launch, acc_set, pv_set, cmd_we, seq_active;
  logic [EW-1:0] entry, head, act;
  logic [CW-1:0] fifo_cnt, cnt_nxt;
  logic          busy, start_r, stub_done, stub_blank, st_wr;

  assign err_blk = acc_r | pv_r;
  assign st_wr   = reg_wr & ~reg_sel;

  flash_seq_check #(.AW(AW), .PG_BITS(PG_BITS), .PROT_BASE(PROT_BASE)) u_seq (
    .clk(clk), .rst(rst), .err_blk(err_blk), .cbef(cbef_r), .ccf(ccf_r),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .stop_req(stop_req), .launch(launch), .acc_set(acc_set), .pv_set(pv_set),
    .cmd_we(cmd_we), .active(seq_active), .entry(entry)
  );

  flash_cmd_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push(launch), .din(entry), .pop(stub_done),
    .head(head), .count(fifo_cnt)
  );

  flash_array_stub #(.PG_BITS(PG_BITS), .LAT(LAT)) u_arr (
    .clk(clk), .rst(rst), .start(start_r), .op(act[EW-1 -: 7]),
    .pg(act[8 +: PG_BITS]), .data(act[7:0]), .done(stub_done), .blank(stub_blank)
  );

  assign cnt_nxt = fifo_cnt + CW'(launch) - CW'(stub_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      start_r <= 1'b0;
      act     <= '0;
    end else begin
      start_r <= 1'b0;
      if (stub_done) begin
        busy <= 1'b0;
      end else if (!busy && fifo_cnt != '0) begin
        busy    <= 1'b1;
        start_r <= 1'b1;
        act     <= head;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cbef_r  <= 1'b1;
      ccf_r   <= 1'b1;
      pv_r    <= 1'b0;
      acc_r   <= 1'b0;
      blank_r <= 1'b0;
      cmd_r   <= '0;
    end else begin
      cbef_r <= (cnt_nxt < CW'(DEPTH));
      ccf_r  <= (cnt_nxt == '0);
      acc_r  <= acc_set | (acc_r & ~(st_wr & reg_wdata[4]));
      pv_r   <= pv_set  | (pv_r  & ~(st_wr & reg_wdata[5]));
      if (launch)
        blank_r <= 1'b0;
      else if (stub_done && act[EW-1 -: 7] == OP_VERIFY)
        blank_r <= stub_blank;
      if (cmd_we) cmd_r <= reg_wdata[6:0];
    end
  end

  assign stat_q = {cbef_r, ccf_r, pv_r, acc_r, 1'b0, blank_r, 2'b00};
  assign cmd_q  = {1'b0, cmd_r};

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] stat_q,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input logic       arr_wr,
  input logic       stop_req,
  input logic       seq_active,
  input logic       stub_done
);

  logic err;
  assign err = stat_q[5] | stat_q[4];

  AST_FULL_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    !stat_q[7] |-> !stat_q[6]); // R2

  AST_CC_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[6]) |-> $past(stub_done)); // R3

  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (seq_active && reg_wr && !reg_sel && !reg_wdata[7] && !arr_wr && !err)
      |=> stat_q[4]); // R4

  AST_W0_KEEPS_AE: assert property (@(posedge clk) disable iff (rst)
    (stat_q[4] && !(reg_wr && !reg_sel && reg_wdata[4])) |=> stat_q[4]); // R7

  AST_ERR_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (err && stat_q[6] && reg_wr && !reg_sel && reg_wdata[7]) |=> stat_q[6]); // R8

  AST_STOP_BUSY: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !stat_q[6]) |=> stat_q[4]); // R9

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst(rst), .stat_q(stat_q), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .arr_wr(arr_wr), .stop_req(stop_req),
  .seq_active(seq_active), .stub_done(stub_done)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

  localparam int AW = 10, PG_BITS = 3, PROT_BASE = 'h300, DEPTH = 2, LAT = 4;
  localparam int NPG = 1 << PG_BITS;

  logic clk = 1'b0, rst = 1'b1;
  logic arr_wr = 0, reg_wr = 0, reg_sel = 0, stop_req = 0;
  logic [AW-1:0] arr_addr = '0;
  logic [7:0] arr_wdata = '0, reg_wdata = '0;
  logic [7:0] stat_q, cmd_q;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit compare_on = 0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .PG_BITS(PG_BITS), .PROT_BASE(PROT_BASE),
                  .DEPTH(DEPTH), .LAT(LAT)) uut (
    .clk(clk), .rst(rst), .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .stop_req(stop_req),
    .stat_q(stat_q), .cmd_q(cmd_q));

  // ---------------- behavioural reference model ----------------
  typedef struct { int code; int page; int data; } ent_t;
  ent_t q[$];
  ent_t m_act, m_new;
  int m_seq, m_addr, m_data, m_cmd, wc;
  bit m_acc, m_pv, m_blank, m_ccf = 1, m_cbef = 1, m_busy;
  bit m_dirty [NPG];
  longint cyc = 0, m_end;
  bit launch, aset, pset, err, vdone, vres, prot;

  function automatic bit code_ok(int c);
    return c == 'h05 || c == 'h20 || c == 'h25 || c == 'h40 || c == 'h41;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      q.delete(); m_seq = 0; m_addr = 0; m_data = 0; m_cmd = 0;
      m_acc = 0; m_pv = 0; m_blank = 0; m_ccf = 1; m_cbef = 1; m_busy = 0;
      foreach (m_dirty[i]) m_dirty[i] = 0;
    end else begin
      launch = 0; aset = 0; pset = 0; vdone = 0; vres = 0;
      err = m_acc | m_pv;
      if (m_busy && cyc == m_end) begin
        m_busy = 0;
        case (m_act.code)
          'h05: begin vdone = 1; vres = 1; foreach (m_dirty[i]) if (m_dirty[i]) vres = 0; end
          'h20, 'h25: if (m_act.data != 'hFF) m_dirty[m_act.page] = 1;
          'h40: m_dirty[m_act.page] = 0;
          'h41: foreach (m_dirty[i]) m_dirty[i] = 0;
          default: ;
        endcase
        void'(q.pop_front());
      end else if (!m_busy && q.size() > 0) begin
        m_busy = 1; m_end = cyc + LAT + 2; m_act = q[0];
      end
      if (!err) begin
        if (arr_wr) begin
          if (m_seq == 0 && m_cbef) begin m_seq = 1; m_addr = arr_addr; m_data = arr_wdata; end
          else begin aset = 1; m_seq = 0; end
        end else if (reg_wr && reg_sel) begin
          wc = reg_wdata & 'h7F;
          m_cmd = wc;
          prot = (wc == 'h41) ? (PROT_BASE < (1 << AW)) : (m_addr >= PROT_BASE);
          if (m_seq != 1 || !code_ok(wc)) begin aset = 1; m_seq = 0; end
          else if (wc != 'h05 && prot) begin pset = 1; m_seq = 0; end
          else begin m_seq = 2; m_new.code = wc; end
        end else if (reg_wr && !reg_sel) begin
          if (reg_wdata[7]) begin
            if (m_seq == 2) launch = 1; else aset = 1;
            m_seq = 0;
          end else if (m_seq != 0) begin aset = 1; m_seq = 0; end
        end
      end
      if (stop_req && !m_ccf) begin aset = 1; m_seq = 0; end
      m_acc = aset | (m_acc & !(reg_wr && !reg_sel && reg_wdata[4]));
      m_pv  = pset | (m_pv  & !(reg_wr && !reg_sel && reg_wdata[5]));
      if (launch) begin
        m_new.page = m_addr >> (AW - PG_BITS);
        m_new.data = m_data;
        q.push_back(m_new);
        m_blank = 0;
      end else if (vdone) m_blank = vres;
      m_ccf  = (q.size() == 0);
      m_cbef = (q.size() < DEPTH);
    end
  end

  function automatic logic [7:0] m_stat();
    return {m_cbef, m_ccf, m_pv, m_acc, 1'b0, m_blank, 2'b00};
  endfunction

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      checks++;
      if (stat_q !== m_stat() || cmd_q !== {1'b0, m_cmd[6:0]}) begin
        errors++;
        $display("FAIL %s per-cycle: stat=%h cmd=%h expected stat=%h cmd=%h",
                 cur_req, stat_q, cmd_q, m_stat(), {1'b0, m_cmd[6:0]});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic awr(int a, int d);
    arr_wr = 1; arr_addr = AW'(a); arr_wdata = 8'(d);
    @(negedge clk); arr_wr = 0;
  endtask

  task automatic rwr(bit s, int d);
    reg_wr = 1; reg_sel = s; reg_wdata = 8'(d);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic stop_pulse();
    stop_req = 1; @(negedge clk); stop_req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cc(output int n);
    n = 0;
    while (!stat_q[6] && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic run_cmd(int a, int d, int c);
    int n;
    awr(a, d); rwr(1, c); rwr(0, 'h80);
    wait_cc(n);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    rst = 0;
    compare_on = 1;
    idle(1);
    cur_req = "R1";
    chk("R1 status after reset", stat_q, 'hC0);
    chk("R1 command after reset", cmd_q, 'h00);

    cur_req = "R10";
    run_cmd('h000, 'hFF, 'h05);
    chk("R10 erase check on clean array", stat_q, 'hC4);

    cur_req = "R12";
    awr('h010, 'h12); rwr(1, 'h20); rwr(0, 'h80);
    chk("R2 CC clears, BE stays with free slot", stat_q, 'h80);
    wait_cc(n);
    chk("R12 single command latency", n, LAT + 3);
    chk("R11 command register bit 7 clear", cmd_q, 'h20);
    idle(1);

    cur_req = "R10";
    run_cmd('h000, 'hFF, 'h05);
    chk("R10 erase check sees programmed page", stat_q, 'hC0);
    rwr(0, 'h44); idle(1);
    chk("R10 writes to CC and BL ignored", stat_q, 'hC0);

    cur_req = "R3";
    awr('h080, 'h5A); rwr(1, 'h25); rwr(0, 'h80);
    awr('h081, 'h5B); rwr(1, 'h25); rwr(0, 'h80);
    chk("R2 BE clear with two commands held", stat_q, 'h00);
    wait_cc(n);
    chk("R12 chained command latency", n, 2 * LAT + 3);
    idle(2);

    cur_req = "R4";
    rwr(0, 'h00); idle(1);
    chk("R4 write 0 to BE outside sequence", stat_q, 'hC0);
    awr('h020, 'h01); rwr(0, 'h00); idle(1);
    chk("R4 abort after array write", stat_q, 'hD0);

    cur_req = "R8";
    awr('h030, 'h00); rwr(1, 'h40); rwr(0, 'h80); idle(2);
    chk("R8 sequence ignored while AE set", stat_q, 'hD0);
    chk("R8 command register unchanged", cmd_q, 'h25);
    cur_req = "R7";
    rwr(0, 'h00); idle(1);
    chk("R7 write 0 keeps AE", stat_q, 'hD0);
    rwr(0, 'h10); idle(1);
    chk("R7 write 1 clears AE", stat_q, 'hC0);

    cur_req = "R5";
    awr('h040, 'h00); rwr(1, 'h33); idle(1);
    chk("R5 undefined code", stat_q, 'hD0);
    rwr(0, 'h10);
    rwr(1, 'h20); idle(1);
    chk("R5 command without array write", stat_q, 'hD0);
    rwr(0, 'h10);
    awr('h040, 'h00); awr('h041, 'h00); idle(1);
    chk("R5 second array write", stat_q, 'hD0);
    rwr(0, 'h10);
    awr('h040, 'h00); rwr(0, 'h80); idle(1);
    chk("R5 launch without code", stat_q, 'hD0);
    rwr(0, 'h10); idle(1);

    cur_req = "R6";
    awr('h345, 'h00); rwr(1, 'h20); idle(1);
    chk("R6 program of protected page", stat_q, 'hE0);
    rwr(0, 'h80); idle(1);
    chk("R8 launch ignored while PV set", stat_q, 'hE0);
    rwr(0, 'h00); idle(1);
    chk("R7 write 0 keeps PV", stat_q, 'hE0);
    rwr(0, 'h20); idle(1);
    chk("R7 write 1 clears PV", stat_q, 'hC0);
    awr('h000, 'h00); rwr(1, 'h41); idle(1);
    chk("R6 full erase with protection", stat_q, 'hE0);
    rwr(0, 'h20); idle(1);

    cur_req = "R9";
    stop_pulse(); idle(1);
    chk("R9 stop while complete", stat_q, 'hC0);
    awr('h100, 'h00); rwr(1, 'h20); rwr(0, 'h80);
    stop_pulse(); idle(1);
    chk("R9 stop while busy sets AE", stat_q[4], 1);
    wait_cc(n); idle(1);
    rwr(0, 'h10); idle(1);

    cur_req = "R10";
    run_cmd('h000, 'hFF, 'h40);
    run_cmd('h080, 'hFF, 'h40);
    run_cmd('h100, 'hFF, 'h40);
    run_cmd('h000, 'hFF, 'h05);
    chk("R10 erase check after page erases", stat_q, 'hC4);
    awr('h200, 'h77); rwr(1, 'h20); rwr(0, 'h80);
    chk("R10 launch clears BL", stat_q[2], 0);
    wait_cc(n); idle(2);
    chk("R11 reserved status bits", stat_q & 'h0B, 0);

    compare_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule